// File: doc/BRIEF.md
# Fair Thread Lock Arbiter

This block arbitrates one global lock among a set of hardware threads. Each thread raises a one-cycle lock strobe to take the lock and an unlock strobe to give it back. The block tracks every thread in one of four states: free, waiting, owner, or queued. Queued means the lock has been handed to the thread but the thread has not yet retried. A single status bit shows whether any thread holds or has been handed the lock.

When a holder releases, the lock is not made free. It passes at once to the next waiting thread after the releaser, searching in circular index order. That thread becomes queued, its halt request drops, and it receives a one-cycle wake pulse. When the woken thread retries its lock, it becomes owner and is told to advance. Misuse is reported on a per-thread error pulse. Misuse means taking the lock a second time, or releasing a lock the thread does not own.

Strobes that arrive together are stored and served one per cycle. The block never loses a request, and the pipeline and interrupt logic around it see a single, well-ordered stream of results.

Top module: `hwlock_fair`

## Requirements
- R1: While `rst_n` is low, and after it rises with no strobes, `locked`, `halt`, `advance`, `wake` and `err` are all zero, and every thread is free.
- R2: A lock served while `locked` is 0 makes the thread owner and sets `locked`. The thread's `advance` bit pulses for one cycle, in the cycle after the strobe is served.
- R3: A lock served from a queued thread makes it owner and pulses its `advance` bit. `locked` stays 1.
- R4: A lock served from the current owner pulses both `err` and `advance` for that thread and raises its `halt`. The thread stays owner. That `halt` stays high until the thread makes a valid unlock.
- R5: A lock served while `locked` is 1, from a thread that is neither owner nor queued, makes the thread wait. Its `halt` goes high and no `advance` pulse is given.
- R6: An unlock served while `locked` is 0, or from a thread that is not owner, pulses that thread's `err` bit and changes no state. `locked`, `halt` and all later results are unaffected.
- R7: A valid unlock with no thread waiting frees the releaser and clears `locked`.
- R8: A valid unlock with threads waiting frees the releaser and searches index releaser+1, releaser+2, … modulo N_THREADS. The first waiting thread found becomes queued and `locked` stays 1. That thread's `wake` bit pulses for one cycle, and its `halt` drops in the same cycle.
- R9: One strobe is served per cycle. Pending unlocks are served before pending locks, and each kind is served from the lowest thread index up. Unserved strobes are held until they are served.
- R10: At most one thread is owner or queued at any time, and `locked` is 1 exactly when one thread is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lock_req | input | N_THREADS | One-cycle lock strobe per thread (bit i = thread i) |
| unlock_req | input | N_THREADS | One-cycle unlock strobe per thread |
| advance | output | N_THREADS | One-cycle pulse: thread may proceed past its lock |
| halt | output | N_THREADS | Level: thread must stall (waiting, or double-locked owner) |
| wake | output | N_THREADS | One-cycle pulse: lock handed to this waiting thread |
| err | output | N_THREADS | One-cycle pulse: misuse by this thread |
| locked | output | 1 | Lock held or handed to a thread |

## Verification
A strobe that is served at once, with no older pending strobes, produces its `advance`, `wake` or `err` pulse in the cycle right after the clock edge that samples it. `halt` and `locked` change at that same edge. A strobe that has to wait behind others produces its result one cycle later for each strobe served ahead of it, following R9's order. The bench drives strobes on the falling edge and reads every output on the next falling edge. It compares against a behavioural model that advances at each rising edge, so each result is read in the exact cycle it is due and nowhere else. Directed sequences cover the wrap-around handoff, the double lock, invalid unlocks, and simultaneous strobes. A long random phase follows them.

// File: rtl/hwlock_pkg.sv
package hwlock_pkg;

  // Per-thread lock state
  typedef enum logic [1:0] {
    TS_FREE = 2'd0,
    TS_WAIT = 2'd1,
    TS_OWN  = 2'd2,
    TS_QUED = 2'd3
  } tstate_t;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/hwlock_lowpick.sv
// Lowest-index selector: one-hot and binary index of the lowest set bit.
module hwlock_lowpick #(
  parameter int WIDTH = 6,
  parameter int IDX_W = 3
) (
  input  logic [WIDTH-1:0] req_vec,
  output logic [WIDTH-1:0] pick_oh,
  output logic [IDX_W-1:0] pick_idx,
  output logic             pick_any
);

  always_comb begin
    pick_oh  = '0;
    pick_idx = '0;
    pick_any = 1'b0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (req_vec[i]) begin
        pick_oh    = '0;
        pick_oh[i] = 1'b1;
        pick_idx   = IDX_W'(i);
        pick_any   = 1'b1;
      end
    end
  end

endmodule

// File: rtl/hwlock_rrpick.sv
// Circular search: first candidate strictly after base_idx, wrapping modulo WIDTH.
module hwlock_rrpick #(
  parameter int WIDTH = 6,
  parameter int IDX_W = 3
) (
  input  logic [WIDTH-1:0] cand_vec,
  input  logic [IDX_W-1:0] base_idx,
  output logic [WIDTH-1:0] hit_oh,
  output logic             hit_any
);

  always_comb begin
    hit_oh  = '0;
    hit_any = 1'b0;
    for (int k = 1; k <= WIDTH; k++) begin
      int pos;
      pos = (int'(base_idx) + k) % WIDTH;
      if (!hit_any && cand_vec[pos]) begin
        hit_oh[pos] = 1'b1;
        hit_any     = 1'b1;
      end
    end
  end

endmodule

// File: rtl/hwlock_slot.sv
// State of one thread: lock state plus the double-lock halt flag.
module hwlock_slot
  import hwlock_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ev_grant,
  input  logic    ev_park,
  input  logic    ev_double,
  input  logic    ev_release,
  input  logic    ev_handoff,
  output tstate_t st_q,
  output logic    hang_q
);

  tstate_t st_d;
  logic    hang_d;
  logic    slot_en;

  assign slot_en = ev_grant | ev_park | ev_double | ev_release | ev_handoff;

  always_comb begin
    st_d   = st_q;
    hang_d = hang_q;
    if (ev_release) begin
      st_d   = TS_FREE;
      hang_d = 1'b0;
    end else if (ev_handoff) begin
      st_d = TS_QUED;
    end else if (ev_grant) begin
      st_d = TS_OWN;
    end else if (ev_park) begin
      st_d = TS_WAIT;
    end
    if (ev_double) begin
      hang_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TS_FREE;
      hang_q <= 1'b0;
    end else if (slot_en) begin
      st_q   <= st_d;
      hang_q <= hang_d;
    end
  end

endmodule

// File: rtl/hwlock_fair.sv
// Fair multi-thread lock: serialised request service, round-robin handoff.
module hwlock_fair
  import hwlock_pkg::*;
#(
  parameter int N_THREADS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_THREADS-1:0] lock_req,
  input  logic [N_THREADS-1:0] unlock_req,
  output logic [N_THREADS-1:0] advance,
  output logic [N_THREADS-1:0] halt,
  output logic [N_THREADS-1:0] wake,
  output logic [N_THREADS-1:0] err,
  output logic                 locked
);

  localparam int IDX_W = idx_width(N_THREADS);

  // Pending strobes and registered pulses
  logic [N_THREADS-1:0] pend_lk_q, pend_lk_d;
  logic [N_THREADS-1:0] pend_ul_q, pend_ul_d;
  logic [N_THREADS-1:0] adv_q, adv_d;
  logic [N_THREADS-1:0] wake_q, wake_d;
  logic [N_THREADS-1:0] err_q, err_d;
  logic                 locked_q, locked_d, locked_en;

  // Effective request vectors
  logic [N_THREADS-1:0] eff_lk, eff_ul;

  // Selector results
  logic [N_THREADS-1:0] ul_oh, lk_oh, hand_oh;
  logic [IDX_W-1:0]     ul_idx, lk_idx;
  logic                 ul_any, lk_any, hand_any;

  // Per-thread state views
  tstate_t              st_vec [N_THREADS];
  logic [N_THREADS-1:0] hang_vec;
  logic [N_THREADS-1:0] own_vec, wait_vec, qued_vec;

  // Decoded operation
  logic sel_ul, sel_lk;
  logic ul_ok;
  logic lk_free, lk_qued, lk_dbl, lk_park;
  logic [N_THREADS-1:0] ev_grant, ev_park, ev_double, ev_release, ev_handoff;

  assign eff_lk = pend_lk_q | lock_req;
  assign eff_ul = pend_ul_q | unlock_req;

  hwlock_lowpick #(.WIDTH(N_THREADS), .IDX_W(IDX_W)) u_ulpick (
    .req_vec  (eff_ul),
    .pick_oh  (ul_oh),
    .pick_idx (ul_idx),
    .pick_any (ul_any)
  );

  hwlock_lowpick #(.WIDTH(N_THREADS), .IDX_W(IDX_W)) u_lkpick (
    .req_vec  (eff_lk),
    .pick_oh  (lk_oh),
    .pick_idx (lk_idx),
    .pick_any (lk_any)
  );

  hwlock_rrpick #(.WIDTH(N_THREADS), .IDX_W(IDX_W)) u_rrpick (
    .cand_vec (wait_vec),
    .base_idx (ul_idx),
    .hit_oh   (hand_oh),
    .hit_any  (hand_any)
  );

  // Per-thread state slots
  for (genvar t = 0; t < N_THREADS; t++) begin : g_slot
    hwlock_slot u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev_grant   (ev_grant[t]),
      .ev_park    (ev_park[t]),
      .ev_double  (ev_double[t]),
      .ev_release (ev_release[t]),
      .ev_handoff (ev_handoff[t]),
      .st_q       (st_vec[t]),
      .hang_q     (hang_vec[t])
    );
    assign own_vec[t]  = (st_vec[t] == TS_OWN);
    assign wait_vec[t] = (st_vec[t] == TS_WAIT);
    assign qued_vec[t] = (st_vec[t] == TS_QUED);
  end

  // Operation decode: unlocks before locks
  always_comb begin
    sel_ul  = ul_any;
    sel_lk  = lk_any & ~ul_any;
    ul_ok   = sel_ul & locked_q & (|(ul_oh & own_vec));
    lk_free = sel_lk & ~locked_q;
    lk_qued = sel_lk & locked_q & (|(lk_oh & qued_vec));
    lk_dbl  = sel_lk & locked_q & (|(lk_oh & own_vec));
    lk_park = sel_lk & locked_q & ~lk_qued & ~lk_dbl;
  end

  always_comb begin
    ev_release = ul_ok ? ul_oh : '0;
    ev_handoff = (ul_ok && hand_any) ? hand_oh : '0;
    ev_grant   = (lk_free || lk_qued) ? lk_oh : '0;
    ev_double  = lk_dbl ? lk_oh : '0;
    ev_park    = lk_park ? lk_oh : '0;
  end

  // Next-state for shared registers
  always_comb begin
    pend_lk_d = eff_lk & ~(sel_lk ? lk_oh : '0);
    pend_ul_d = eff_ul & ~(sel_ul ? ul_oh : '0);
    adv_d     = ev_grant | ev_double;
    wake_d    = ev_handoff;
    err_d     = ev_double | ((sel_ul && !ul_ok) ? ul_oh : '0);
    locked_en = ul_ok | lk_free;
    locked_d  = locked_q;
    if (ul_ok) begin
      locked_d = hand_any;
    end else if (lk_free) begin
      locked_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_lk_q <= '0;
      pend_ul_q <= '0;
      adv_q     <= '0;
      wake_q    <= '0;
      err_q     <= '0;
    end else begin
      pend_lk_q <= pend_lk_d;
      pend_ul_q <= pend_ul_d;
      adv_q     <= adv_d;
      wake_q    <= wake_d;
      err_q     <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
    end else if (locked_en) begin
      locked_q <= locked_d;
    end
  end

  assign advance = adv_q;
  assign wake    = wake_q;
  assign err     = err_q;
  assign locked  = locked_q;
  assign halt    = wait_vec | hang_vec;

endmodule

// File: rtl/hwlock_chk.sv
// Property checker bound to hwlock_fair.
module hwlock_chk #(
  parameter int N_THREADS = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_THREADS-1:0] advance,
  input logic [N_THREADS-1:0] halt,
  input logic [N_THREADS-1:0] wake,
  input logic [N_THREADS-1:0] err,
  input logic                 locked,
  input logic [N_THREADS-1:0] own_vec,
  input logic [N_THREADS-1:0] qued_vec
);

  assert_single_holder_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(own_vec | qued_vec) <= 1);

  assert_locked_tracks_holder_R10: assert property (@(posedge clk) disable iff (!rst_n)
    locked == (|(own_vec | qued_vec)));

  assert_one_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wake));

  assert_one_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(advance) && $onehot0(err));

  assert_rise_needs_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (|advance));

  assert_bad_unlock_keeps_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(err & ~advance)) |-> $stable(locked));

  for (genvar g = 0; g < N_THREADS; g++) begin : g_thr
    assert_wake_drops_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wake[g] |-> !halt[g]);
    assert_double_halts_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (err[g] && advance[g]) |-> (halt[g] && own_vec[g]));
  end

endmodule

bind hwlock_fair hwlock_chk #(.N_THREADS(N_THREADS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .advance  (advance),
  .halt     (halt),
  .wake     (wake),
  .err      (err),
  .locked   (locked),
  .own_vec  (own_vec),
  .qued_vec (qued_vec)
);

// File: tb/hwlock_fair_tb.sv
module hwlock_fair_tb;

  localparam int N = 6;
  localparam int S_FREE = 0;
  localparam int S_WAIT = 1;
  localparam int S_OWN  = 2;
  localparam int S_QUED = 3;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] lock_req;
  logic [N-1:0] unlock_req;
  logic [N-1:0] advance, halt, wake, err;
  logic         locked;

  int n_tests;
  int n_fail;
  int cyc;
  bit done;
  bit cmp_on;

  hwlock_fair #(.N_THREADS(N)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .lock_req   (lock_req),
    .unlock_req (unlock_req),
    .advance    (advance),
    .halt       (halt),
    .wake       (wake),
    .err        (err),
    .locked     (locked)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Behavioural reference model
  int           m_st   [N];
  bit           m_pl   [N];
  bit           m_pu   [N];
  bit           m_hang [N];
  bit           m_locked;
  logic [N-1:0] m_adv, m_wake, m_err;

  function automatic logic [N-1:0] m_halt();
    logic [N-1:0] h;
    for (int i = 0; i < N; i++) h[i] = (m_st[i] == S_WAIT) || m_hang[i];
    return h;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_st[i] = S_FREE; m_pl[i] = 0; m_pu[i] = 0; m_hang[i] = 0;
      end
      m_locked = 0; m_adv = '0; m_wake = '0; m_err = '0;
    end else begin
      int su, sl, h;
      bit el [N];
      bit eu [N];
      su = -1; sl = -1; h = -1;
      m_adv = '0; m_wake = '0; m_err = '0;
      for (int i = 0; i < N; i++) begin
        el[i] = m_pl[i] | lock_req[i];
        eu[i] = m_pu[i] | unlock_req[i];
      end
      for (int i = 0; i < N; i++) begin
        if (eu[i] && su < 0) su = i;
        if (el[i] && sl < 0) sl = i;
      end
      if (su >= 0) begin
        eu[su] = 0;
        if (m_locked && m_st[su] == S_OWN) begin
          m_st[su] = S_FREE; m_hang[su] = 0;
          for (int k = 1; k <= N; k++) begin
            int j;
            j = (su + k) % N;
            if (h < 0 && m_st[j] == S_WAIT) h = j;
          end
          if (h >= 0) begin
            m_st[h] = S_QUED; m_wake[h] = 1'b1; m_locked = 1;
          end else begin
            m_locked = 0;
          end
        end else begin
          m_err[su] = 1'b1;
        end
      end else if (sl >= 0) begin
        el[sl] = 0;
        if (!m_locked) begin
          m_st[sl] = S_OWN; m_locked = 1; m_adv[sl] = 1'b1;
        end else if (m_st[sl] == S_QUED) begin
          m_st[sl] = S_OWN; m_adv[sl] = 1'b1;
        end else if (m_st[sl] == S_OWN) begin
          m_err[sl] = 1'b1; m_adv[sl] = 1'b1; m_hang[sl] = 1;
        end else begin
          m_st[sl] = S_WAIT;
        end
      end
      for (int i = 0; i < N; i++) begin
        m_pl[i] = el[i]; m_pu[i] = eu[i];
      end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison with the model
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      check("R2", "advance", advance, m_adv);
      check("R5", "halt", halt, m_halt());
      check("R8", "wake", wake, m_wake);
      check("R6", "err", err, m_err);
      check("R10", "locked", {{(N-1){1'b0}}, locked}, {{(N-1){1'b0}}, m_locked});
    end
  end

  task automatic strobe(input logic [N-1:0] lk, input logic [N-1:0] ul);
    @(negedge clk);
    lock_req = lk; unlock_req = ul;
    @(negedge clk);
    lock_req = '0; unlock_req = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    n_tests = 0; n_fail = 0; cyc = 0; done = 0; cmp_on = 0;
    lock_req = '0; unlock_req = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    check("R1", "halt in reset", halt, '0);
    check("R1", "locked in reset", {5'b0, locked}, '0);
    rst_n = 1'b1;
    cmp_on = 1;
    @(negedge clk);
    check("R1", "advance after reset", advance | wake | err, '0);

    strobe(6'b000100, '0);                       // T2 takes free lock
    check("R2", "grant T2", advance, 6'b000100);
    check("R2", "locked set", {5'b0, locked}, 6'b000001);
    strobe(6'b010000, '0);                       // T4 must wait
    check("R5", "T4 waits", halt, 6'b010000);
    check("R5", "no advance", advance, '0);
    strobe(6'b000001, '0);                       // T0 waits
    check("R5", "T0 waits", halt, 6'b010001);
    strobe('0, 6'b000010);                       // T1 not owner
    check("R6", "bad unlock err", err, 6'b000010);
    check("R6", "halt unchanged", halt, 6'b010001);
    strobe('0, 6'b000100);                       // T2 releases -> T4
    check("R8", "wake T4", wake, 6'b010000);
    check("R8", "halt drops T4", halt, 6'b000001);
    check("R8", "lock kept", {5'b0, locked}, 6'b000001);
    strobe(6'b010000, '0);                       // T4 retries
    check("R3", "queued grant", advance, 6'b010000);
    strobe(6'b010000, '0);                       // double lock
    check("R4", "double err", err, 6'b010000);
    check("R4", "double advance", advance, 6'b010000);
    check("R4", "double halt", halt, 6'b010001);
    strobe('0, 6'b010000);                       // T4 releases, wraps to T0
    check("R8", "wrap wake T0", wake, 6'b000001);
    check("R4", "halt cleared", halt, '0);
    strobe(6'b000001, '0);
    strobe('0, 6'b000001);                       // no waiters
    check("R7", "lock freed", {5'b0, locked}, '0);
    check("R7", "no wake", wake, '0);
    strobe('0, 6'b001000);                       // unlock while free
    check("R6", "unlock while free", err, 6'b001000);
    check("R6", "still free", {5'b0, locked}, '0);

    strobe(6'b101010, '0);                       // simultaneous locks
    check("R9", "lowest first", advance, 6'b000010);
    @(negedge clk);
    check("R9", "T3 next", halt, 6'b001000);
    @(negedge clk);
    check("R9", "T5 last", halt, 6'b101000);
    strobe(6'b000001, 6'b000010);                // unlock beats lock
    check("R9", "unlock first", wake, 6'b001000);
    @(negedge clk);
    check("R9", "lock after", halt, 6'b100001);

    // Random phase, compared against the model every cycle
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      lock_req   = ($urandom_range(0, 3) == 0) ? N'($urandom) : '0;
      unlock_req = ($urandom_range(0, 3) == 0) ? N'($urandom) : '0;
      if (n % 997 == 500) begin
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
      end
    end
    lock_req = '0; unlock_req = '0;
    repeat (20) @(negedge clk);
    finish_run();
  end

endmodule